// File: doc/BRIEF.md
# Multiword DMA Device Handshake Controller

This block is the device side of the request/acknowledge handshake used for multiword DMA on a parallel disk interface. Internal logic starts a transfer with a word count and a direction. The block then raises the request line whenever the internal buffer can serve the next word. It waits for the host's acknowledge. While the acknowledge is held, it moves one 16-bit word for each matching host strobe pulse.

For device-to-host transfers, words come from a valid/ready source stream. The head word is driven onto the data bus while the host holds its read strobe low, and it is popped at the trailing edge of the strobe. For host-to-device transfers, the bus word present at the trailing edge of the write strobe is captured into a one-entry holding register. That register is offered on a valid/ready sink stream. It holds its data until the sink accepts it, and the request line is not raised again while it is occupied. The acknowledge and both strobes are asynchronous. They pass through a two-flop synchronizer before any edge is detected. The request output carries its own enable, which is low whenever the device is not selected.

Top module: `mwdma_dev`

## Requirements
- R1: After reset, dmarq, busy, done, src_ready, snk_valid and dd_oe are all 0.
- R2: After a start with a nonzero word count, busy is 1. dmarq rises only once the buffer side is ready: src_valid=1 when start_dir=0 (device-to-host), or no held word when start_dir=1 (host-to-device).
- R3: Once raised, dmarq stays 1 until the synchronized dmack_n is seen low, and then drops. While dmack_n stays low it is not raised again. When dmack_n returns high with words remaining and the buffer ready, dmarq is raised again.
- R4: In a device-to-host transfer, dd_oe=1 and dd_out equals src_data while both dmack_n and iord_n are low. Each rising edge of iord_n seen while acknowledged, with src_valid=1, gives exactly one src_ready pulse.
- R5: In a host-to-device transfer, the dd_in value present while iowr_n was low, at its rising edge, appears on snk_data with snk_valid=1. It stays there unchanged until snk_ready=1.
- R6: When the last word has moved, done pulses for one cycle and busy returns to 0. dmarq stays 0.
- R7: A strobe pulsed while dmack_n is high, while busy=0, or of the direction opposite to start_dir moves no data: no src_ready, no snk_valid, and the remaining count is unchanged.
- R8: While busy=0, dmack_n is ignored at any level: dmarq stays 0 and busy stays 0.
- R9: dmarq_oe equals dev_sel. While dev_sel=0, dmarq is 0, and the pending request appears once dev_sel returns to 1.
- R10: A start with a word count of 0 gives a done pulse and no request. A start while busy=1 is ignored.
- R11: A write strobe that arrives while a captured word is still waiting for the sink is dropped and not counted. The next request is withheld until the sink accepts the held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | One-cycle pulse that begins a transfer when idle |
| start_dir | input | 1 | 0 = device-to-host, 1 = host-to-device |
| start_words | input | CNT_W | Number of 16-bit words to move |
| dev_sel | input | 1 | Device is the selected drive |
| dmack_n | input | 1 | Host acknowledge, active low, asynchronous |
| iord_n | input | 1 | Host read strobe, active low, asynchronous |
| iowr_n | input | 1 | Host write strobe, active low, asynchronous |
| dd_in | input | DATA_W | Data bus as driven by the host |
| dd_out | output | DATA_W | Data bus value driven by the device |
| dd_oe | output | 1 | Enable for dd_out onto the bus |
| dmarq | output | 1 | DMA request level |
| dmarq_oe | output | 1 | Enable for the request pin driver |
| src_valid | input | 1 | Source stream has a word for the host |
| src_data | input | DATA_W | Source stream head word |
| src_ready | output | 1 | Source word consumed this cycle |
| snk_valid | output | 1 | Held host word is available |
| snk_data | output | DATA_W | Held host word |
| snk_ready | input | 1 | Sink accepts the held word this cycle |
| busy | output | 1 | A transfer is active |
| done | output | 1 | One-cycle pulse when the transfer completes |

## Verification
The assertions assume that the host holds each strobe low and high for several device clocks. They also assume the host changes dd_in only after the write strobe has been seen high through the synchronizer, so that the edge and its data meet in the same pipeline stage. The bench drives every asynchronous input on the falling clock edge and keeps each strobe phase five clocks long. It toggles acknowledge only between strobes, which keeps edge detection unambiguous. Sink back-pressure is applied only through snk_ready, so the hold property is exercised with the sink stalled across a second strobe.

// File: rtl/mwdma_pkg.sv
package mwdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PEND  = 2'd1,
    ST_REQ   = 2'd2,
    ST_ACKED = 2'd3
  } seq_state_t;

  typedef enum logic {
    DIR_TO_HOST   = 1'b0,
    DIR_FROM_HOST = 1'b1
  } xfer_dir_t;
endpackage

// File: rtl/mwdma_sync.sv
module mwdma_sync #(
  parameter int W = 1,
  parameter int DEPTH = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= {W{RST_VAL}};
    else        pipe[0] <= din;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[g] <= {W{RST_VAL}};
      else        pipe[g] <= pipe[g-1];
    end
  end

  assign dout = pipe[DEPTH-1];
endmodule

// File: rtl/mwdma_seq.sv
module mwdma_seq
  import mwdma_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_dir,
  input  logic [CNT_W-1:0] start_words,
  input  logic             ack_low,
  input  logic             rd_edge,
  input  logic             wr_edge,
  input  logic             src_valid,
  input  logic             hold_full,
  output seq_state_t       state,
  output xfer_dir_t        dir,
  output logic             req,
  output logic             busy,
  output logic             take_rd,
  output logic             take_wr,
  output logic             done
);
  logic [CNT_W-1:0] remaining;
  logic             buf_ok;
  logic             acked;
  logic             take;

  assign acked   = (state == ST_ACKED) && ack_low;
  assign buf_ok  = (dir == DIR_FROM_HOST) ? !hold_full : src_valid;
  assign take_rd = acked && rd_edge && (dir == DIR_TO_HOST) && src_valid;
  assign take_wr = acked && wr_edge && (dir == DIR_FROM_HOST) && !hold_full;
  assign take    = take_rd || take_wr;
  assign req     = (state == ST_REQ);
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      dir       <= DIR_TO_HOST;
      remaining <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (start_words == '0) begin
              done <= 1'b1;
            end else begin
              remaining <= start_words;
              dir       <= xfer_dir_t'(start_dir);
              state     <= ST_PEND;
            end
          end
        end
        ST_PEND: begin
          if (buf_ok) state <= ST_REQ;
        end
        ST_REQ: begin
          if (ack_low) state <= ST_ACKED;
        end
        ST_ACKED: begin
          if (take) begin
            remaining <= remaining - CNT_W'(1);
            if (remaining == CNT_W'(1)) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end else if (!ack_low) begin
            state <= ST_PEND;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mwdma_rdpath.sv
module mwdma_rdpath
  import mwdma_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  seq_state_t        state,
  input  xfer_dir_t         dir,
  input  logic              ack_low,
  input  logic              iord_low,
  input  logic [DATA_W-1:0] src_data,
  output logic [DATA_W-1:0] dd_out,
  output logic              dd_oe
);
  assign dd_oe  = (state == ST_ACKED) && (dir == DIR_TO_HOST) && ack_low && iord_low;
  assign dd_out = src_data;
endmodule

// File: rtl/mwdma_wrpath.sv
module mwdma_wrpath #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_wr,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              snk_ready,
  output logic              snk_valid,
  output logic [DATA_W-1:0] snk_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snk_valid <= 1'b0;
      snk_data  <= '0;
    end else if (take_wr) begin
      snk_valid <= 1'b1;
      snk_data  <= cap_data;
    end else if (snk_valid && snk_ready) begin
      snk_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mwdma_dev.sv
module mwdma_dev
  import mwdma_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_dir,
  input  logic [CNT_W-1:0]  start_words,
  input  logic              dev_sel,
  input  logic              dmack_n,
  input  logic              iord_n,
  input  logic              iowr_n,
  input  logic [DATA_W-1:0] dd_in,
  output logic [DATA_W-1:0] dd_out,
  output logic              dd_oe,
  output logic              dmarq,
  output logic              dmarq_oe,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  output logic              snk_valid,
  output logic [DATA_W-1:0] snk_data,
  input  logic              snk_ready,
  output logic              busy,
  output logic              done
);
  localparam int CTL_W = 3;
  localparam int DATA_DEPTH = SYNC_STAGES + 1;

  logic [CTL_W-1:0]  ctl_raw, ctl_now, ctl_prev;
  logic [DATA_W-1:0] cap_data;
  logic              ack_low, rd_edge, wr_edge, iord_low;
  logic              seq_req, take_rd, take_wr;
  seq_state_t        state;
  xfer_dir_t         dir;

  assign ctl_raw = {iowr_n, iord_n, dmack_n};

  mwdma_sync #(.W(CTL_W), .DEPTH(SYNC_STAGES), .RST_VAL(1'b1)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .din(ctl_raw), .dout(ctl_now)
  );

  mwdma_sync #(.W(CTL_W), .DEPTH(1), .RST_VAL(1'b1)) u_ctl_prev (
    .clk(clk), .rst_n(rst_n), .din(ctl_now), .dout(ctl_prev)
  );

  mwdma_sync #(.W(DATA_W), .DEPTH(DATA_DEPTH), .RST_VAL(1'b0)) u_data_sync (
    .clk(clk), .rst_n(rst_n), .din(dd_in), .dout(cap_data)
  );

  assign ack_low  = !ctl_now[0];
  assign iord_low = !ctl_now[1];
  assign rd_edge  = ctl_now[1] && !ctl_prev[1];
  assign wr_edge  = ctl_now[2] && !ctl_prev[2];

  mwdma_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_dir(start_dir), .start_words(start_words),
    .ack_low(ack_low), .rd_edge(rd_edge), .wr_edge(wr_edge),
    .src_valid(src_valid), .hold_full(snk_valid),
    .state(state), .dir(dir), .req(seq_req), .busy(busy),
    .take_rd(take_rd), .take_wr(take_wr), .done(done)
  );

  mwdma_rdpath #(.DATA_W(DATA_W)) u_rdpath (
    .state(state), .dir(dir), .ack_low(ack_low), .iord_low(iord_low),
    .src_data(src_data), .dd_out(dd_out), .dd_oe(dd_oe)
  );

  mwdma_wrpath #(.DATA_W(DATA_W)) u_wrpath (
    .clk(clk), .rst_n(rst_n), .take_wr(take_wr), .cap_data(cap_data),
    .snk_ready(snk_ready), .snk_valid(snk_valid), .snk_data(snk_data)
  );

  assign src_ready = take_rd;
  assign dmarq     = seq_req && dev_sel;
  assign dmarq_oe  = dev_sel;
endmodule

// File: rtl/mwdma_dev_chk.sv
module mwdma_dev_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dmarq,
  input logic              dmarq_oe,
  input logic              busy,
  input logic              done,
  input logic              src_ready,
  input logic              snk_valid,
  input logic              snk_ready,
  input logic [DATA_W-1:0] snk_data,
  input logic              req,
  input logic              ack_low
);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack_low) |=> req);

  // R9
  req_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmarq |-> dmarq_oe);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !dmarq));

  // R7
  pop_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> (busy && !req && ack_low));

  // R5
  snk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snk_valid && !snk_ready) |=> (snk_valid && $stable(snk_data)));

  // R8
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dmarq);
endmodule

bind mwdma_dev mwdma_dev_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dmarq(dmarq), .dmarq_oe(dmarq_oe),
  .busy(busy), .done(done), .src_ready(src_ready),
  .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_data(snk_data),
  .req(seq_req), .ack_low(ack_low)
);

// File: tb/mwdma_dev_bench.sv
`timescale 1ns/1ps
module mwdma_dev_bench;
  localparam int DW = 16;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, start_dir = 1'b0;
  logic [CW-1:0] start_words = '0;
  logic dev_sel = 1'b1, dmack_n = 1'b1, iord_n = 1'b1, iowr_n = 1'b1;
  logic [DW-1:0] dd_in = '0;
  logic [DW-1:0] dd_out, snk_data, src_data;
  logic dd_oe, dmarq, dmarq_oe, src_valid = 1'b0, src_ready;
  logic snk_valid, snk_ready = 1'b1, busy, done;

  int checks = 0, errors = 0;
  int src_pops = 0, sink_cnt = 0, done_cnt = 0, cyc = 0;
  logic [DW-1:0] sink_mem [32];

  always #4 clk = ~clk;

  assign src_data = 16'hA000 + src_pops[15:0];

  mwdma_dev #(.DATA_W(DW), .CNT_W(CW)) u_mwdma_dev (
    .clk(clk), .rst_n(rst_n), .start(start), .start_dir(start_dir),
    .start_words(start_words), .dev_sel(dev_sel), .dmack_n(dmack_n),
    .iord_n(iord_n), .iowr_n(iowr_n), .dd_in(dd_in), .dd_out(dd_out),
    .dd_oe(dd_oe), .dmarq(dmarq), .dmarq_oe(dmarq_oe),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .snk_valid(snk_valid), .snk_data(snk_data), .snk_ready(snk_ready),
    .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    if (src_valid && src_ready) src_pops <= src_pops + 1;
    if (snk_valid && snk_ready) begin
      sink_mem[sink_cnt[4:0]] <= snk_data;
      sink_cnt <= sink_cnt + 1;
    end
    if (done) done_cnt <= done_cnt + 1;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kick(input logic d, input int words);
    @(negedge clk);
    start = 1'b1; start_dir = d; start_words = CW'(words);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_req(input string tag);
    int n = 0;
    while (!dmarq && n < 40) begin @(negedge clk); n++; end
    chk(dmarq == 1'b1, tag, int'(dmarq), 1);
  endtask

  task automatic ack(input logic lvl);
    @(negedge clk); dmack_n = lvl; cycles(5);
  endtask

  task automatic rd_strobe(input logic check_bus, input int exp_idx);
    @(negedge clk); iord_n = 1'b0; cycles(5);
    if (check_bus) begin
      chk(dd_oe == 1'b1, "R4 dd_oe", int'(dd_oe), 1);
      chk(dd_out == 16'hA000 + exp_idx[15:0], "R4 dd_out", int'(dd_out), 32'hA000 + exp_idx);
    end
    iord_n = 1'b1; cycles(5);
  endtask

  task automatic wr_strobe(input logic [DW-1:0] w);
    @(negedge clk); dd_in = w; iowr_n = 1'b0; cycles(5);
    iowr_n = 1'b1; cycles(5);
    dd_in = 16'h0000;
  endtask

  task automatic t_reset;
    chk(dmarq == 0 && busy == 0 && done == 0, "R1 ctrl", {dmarq, busy, done}, 0);
    chk(src_ready == 0 && snk_valid == 0 && dd_oe == 0, "R1 data", {src_ready, snk_valid, dd_oe}, 0);
  endtask

  task automatic t_read3;
    int p0 = src_pops, d0 = done_cnt;
    src_valid = 1'b1;
    kick(1'b0, 3);
    chk(busy == 1'b1, "R2 busy", int'(busy), 1);
    wait_req("R2 read request");
    cycles(6);
    chk(dmarq == 1'b1, "R3 held without ack", int'(dmarq), 1);
    ack(1'b0);
    chk(dmarq == 1'b0, "R3 dropped after ack", int'(dmarq), 0);
    rd_strobe(1'b1, p0);
    chk(src_pops == p0 + 1, "R4 one pop", src_pops, p0 + 1);
    chk(dmarq == 1'b0, "R3 no reraise under ack", int'(dmarq), 0);
    ack(1'b1);
    chk(dmarq == 1'b1, "R3 reraised", int'(dmarq), 1);
    ack(1'b0);
    rd_strobe(1'b1, p0 + 1);
    rd_strobe(1'b1, p0 + 2);
    chk(src_pops == p0 + 3, "R4 pops", src_pops, p0 + 3);
    chk(done_cnt == d0 + 1 && busy == 1'b0, "R6 read done", done_cnt - d0, 1);
    ack(1'b1);
    chk(dmarq == 1'b0, "R6 request stays low", int'(dmarq), 0);
  endtask

  task automatic t_write2;
    int s0 = sink_cnt, d0 = done_cnt;
    snk_ready = 1'b1;
    kick(1'b1, 2);
    wait_req("R2 write request");
    ack(1'b0);
    wr_strobe(16'h1234);
    wr_strobe(16'h5678);
    ack(1'b1);
    chk(sink_cnt == s0 + 2, "R5 sink count", sink_cnt, s0 + 2);
    chk(sink_mem[s0[4:0]] == 16'h1234, "R5 word0", int'(sink_mem[s0[4:0]]), 32'h1234);
    chk(sink_mem[s0[4:0] + 5'd1] == 16'h5678, "R5 word1", int'(sink_mem[s0[4:0] + 5'd1]), 32'h5678);
    chk(done_cnt == d0 + 1 && busy == 1'b0, "R6 write done", done_cnt - d0, 1);
  endtask

  task automatic t_ignore;
    int p0 = src_pops, s0 = sink_cnt, d0 = done_cnt;
    ack(1'b0);
    chk(dmarq == 1'b0 && busy == 1'b0, "R8 idle ack ignored", {dmarq, busy}, 0);
    rd_strobe(1'b0, 0);
    wr_strobe(16'hDEAD);
    chk(src_pops == p0 && sink_cnt == s0, "R7 idle strobes", src_pops - p0 + sink_cnt - s0, 0);
    chk(busy == 1'b0 && done_cnt == d0, "R8 idle state", int'(busy), 0);
    ack(1'b1);
    kick(1'b0, 2);
    wait_req("R7 request");
    rd_strobe(1'b0, 0);
    chk(src_pops == p0, "R7 strobe without ack", src_pops, p0);
    ack(1'b0);
    wr_strobe(16'hBEEF);
    chk(sink_cnt == s0 && snk_valid == 1'b0, "R7 wrong direction", sink_cnt - s0, 0);
    rd_strobe(1'b1, p0);
    rd_strobe(1'b1, p0 + 1);
    chk(src_pops == p0 + 2 && done_cnt == d0 + 1, "R7 count intact", src_pops - p0, 2);
    ack(1'b1);
  endtask

  task automatic t_deselect;
    @(negedge clk); dev_sel = 1'b0;
    kick(1'b0, 1);
    cycles(10);
    chk(dmarq_oe == 1'b0 && dmarq == 1'b0, "R9 deselected", {dmarq_oe, dmarq}, 0);
    @(negedge clk); dev_sel = 1'b1;
    cycles(2);
    chk(dmarq_oe == 1'b1 && dmarq == 1'b1, "R9 reselected", {dmarq_oe, dmarq}, 3);
    ack(1'b0);
    rd_strobe(1'b0, 0);
    ack(1'b1);
  endtask

  task automatic t_zero_and_busy;
    int d0 = done_cnt;
    kick(1'b0, 0);
    cycles(4);
    chk(done_cnt == d0 + 1 && busy == 1'b0 && dmarq == 1'b0, "R10 zero count", done_cnt - d0, 1);
    kick(1'b0, 1);
    kick(1'b0, 5);
    wait_req("R10 request");
    ack(1'b0);
    rd_strobe(1'b0, 0);
    ack(1'b1);
    chk(busy == 1'b0 && done_cnt == d0 + 2, "R10 start while busy ignored", int'(busy), 0);
  endtask

  task automatic t_src_wait;
    @(negedge clk); src_valid = 1'b0;
    kick(1'b0, 1);
    cycles(10);
    chk(dmarq == 1'b0 && busy == 1'b1, "R2 waits for source", {dmarq, busy}, 1);
    @(negedge clk); src_valid = 1'b1;
    wait_req("R2 source ready");
    ack(1'b0);
    rd_strobe(1'b0, 0);
    ack(1'b1);
  endtask

  task automatic t_sink_full;
    int s0 = sink_cnt, d0 = done_cnt;
    @(negedge clk); snk_ready = 1'b0;
    kick(1'b1, 2);
    wait_req("R11 request");
    ack(1'b0);
    wr_strobe(16'hAAAA);
    wr_strobe(16'hBBBB);
    ack(1'b1);
    cycles(5);
    chk(snk_valid == 1'b1 && snk_data == 16'hAAAA, "R5 held word", int'(snk_data), 32'hAAAA);
    chk(dmarq == 1'b0 && busy == 1'b1, "R11 request withheld", {dmarq, busy}, 1);
    @(negedge clk); snk_ready = 1'b1;
    wait_req("R11 request after drain");
    ack(1'b0);
    wr_strobe(16'hCCCC);
    ack(1'b1);
    chk(sink_cnt == s0 + 2, "R11 sink count", sink_cnt, s0 + 2);
    chk(sink_mem[s0[4:0] + 5'd1] == 16'hCCCC, "R11 dropped strobe", int'(sink_mem[s0[4:0] + 5'd1]), 32'hCCCC);
    chk(done_cnt == d0 + 1, "R6 done after drain", done_cnt - d0, 1);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cycles(3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    cycles(2);
    t_reset();
    t_read3();
    t_write2();
    t_ignore();
    t_deselect();
    t_zero_and_busy();
    t_src_wait();
    t_sink_full();
    cycles(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule